// File: doc/BRIEF.md
# USB Charger Port Detection Controller

This block is the device-side sequencer that works out what kind of USB port a portable device has been plugged into, and how much current it may draw from it. It takes a 1 ms timebase tick, a VBUS-session-valid flag, a VBUS-below-leakage flag and digitised comparator results for the data lines. From these it drives the enables for the analog pieces: the D+ contact-detect current source and D- pull-down, the primary-detection D+ voltage source and D- current sink, the optional secondary-detection D- voltage source and D+ current sink, the D+ connect pull-up and a VBUS discharge switch.

After VBUS becomes valid, the controller first runs a data-contact phase. That phase is either a plain timeout or a debounced contact check, chosen at build time. Primary detection follows and separates a standard port from a charging port. Secondary detection, when it is built in, then separates a dedicated charger from a charging downstream port. The result is reported as a port-type code with a one-clock "decided" strobe, and as a current-budget code. When VBUS is lost, the controller discharges VBUS and enforces a hold-off time. The next attach then runs the whole sequence again.

All comparator and VBUS flags are synchronised with two flops, so they are sampled two clocks late. All phase lengths are parameters counted in ticks and loaded into one shared 16-bit down-counter at each phase entry.

Top module: `chg_detect`

## Requirements
- R1: With contact detection not built in (USE_DCD=0), the contact-source enables never rise. Primary detection starts T_DCD_TO_MS ticks after the synchronised VBUS-valid flag rises.
- R2: With contact detection built in, dp_isrc_en and dm_pd_en are both high during the contact phase. Primary detection begins early once dp_lt_lgc has been high on T_DCD_DBNC_MS consecutive ticks; otherwise it begins when T_DCD_TO_MS ticks expire.
- R3: During primary detection, dp_vsrc_en and dm_isink_en are high together for exactly T_PRI_MS ticks.
- R4: When primary detection ends, a low dm_gt_ref gives port type 1 (standard port). A high dm_gt_ref means a charging port.
- R5: With secondary detection built in (USE_SEC=1), dm_vsrc_en and dp_isink_en are high for T_SEC_MS ticks. At the end of that phase, a high dp_gt_ref gives type 3 (dedicated charger) and a low one gives type 2 (charging downstream port). Without secondary detection, a charging port is reported as type 3.
- R6: port_type encodes 0 none, 1 standard, 2 charging downstream, 3 dedicated. det_done is high for exactly one clock per attach, in the clock in which port_type first shows the decided non-zero type.
- R7: ilim_code encodes 0 = nothing, 1 = 100 mA, 2 = 500 mA, 3 = 1.5 A. It is 0 with no type, 1 on a standard port until cfg_done is high and then 2, and 3 on either charging type.
- R8: Once the type is decided, dp_pullup_en is high for types 1 and 2. For type 3 it is low when secondary detection is built in; without it, it follows draw_active.
- R9: Within three clocks of vbus_valid falling in any detection or attached state, vbus_dis_en rises. In the same window, port_type and ilim_code go to 0 and every source and the pull-up go off.
- R10: Discharge ends when the synchronised vbus_below_lkg flag is high, or after T_DIS_MS ticks, whichever comes first.
- R11: After discharge, vbus_valid is ignored for T_REATT_MS ticks. A later attach then repeats the full detection sequence and reports again.
- R12: At most one of the contact, primary, secondary, discharge and pull-up groups is enabled at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-clock timebase strobe, one per millisecond |
| vbus_valid | input | 1 | VBUS above session-valid threshold (asynchronous) |
| vbus_below_lkg | input | 1 | VBUS below leakage threshold (asynchronous) |
| dp_gt_ref | input | 1 | D+ above reference comparator (asynchronous) |
| dm_gt_ref | input | 1 | D- above reference comparator (asynchronous) |
| dp_lt_lgc | input | 1 | D+ below low logic level comparator (asynchronous) |
| cfg_done | input | 1 | Device has been configured by the host |
| draw_active | input | 1 | Device draws more than suspend current |
| dp_isrc_en | output | 1 | D+ contact-detect current source enable |
| dm_pd_en | output | 1 | D- contact-detect pull-down enable |
| dp_vsrc_en | output | 1 | D+ primary voltage source enable |
| dm_isink_en | output | 1 | D- primary current sink enable |
| dm_vsrc_en | output | 1 | D- secondary voltage source enable |
| dp_isink_en | output | 1 | D+ secondary current sink enable |
| dp_pullup_en | output | 1 | D+ connect pull-up enable |
| vbus_dis_en | output | 1 | VBUS discharge switch enable |
| port_type | output | 2 | Detected port type code |
| ilim_code | output | 2 | Allowed current budget code |
| det_done | output | 1 | One-clock strobe when the type is decided |

## Verification
The bench builds two instances side by side on shared stimulus. The first has contact detection and secondary detection enabled. The second has both left out, so the timeout-only contact phase and the no-secondary pull-up rule are covered in the same run as the debounce and charger-split paths. Every phase length is shrunk to a few ticks, with a tick every four clocks. This makes the exact primary-phase length, the early-contact versus timeout start, the discharge-timeout exit and the re-attach hold-off cheap to reach on every scenario.

// File: rtl/chg_det_pkg.sv
// Package: shared types for the charger port detection controller.
// Assumes: port-type and current-budget encodings are fixed interface codes.
package chg_det_pkg;

    localparam int TMR_W = 16;

    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_SDP  = 2'd1,
        PORT_CDP  = 2'd2,
        PORT_DCP  = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        ILIM_ZERO  = 2'd0,
        ILIM_100MA = 2'd1,
        ILIM_500MA = 2'd2,
        ILIM_1500MA = 2'd3
    } ilim_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CONTACT   = 3'd1,
        ST_PRIMARY   = 3'd2,
        ST_SECONDARY = 3'd3,
        ST_ATTACHED  = 3'd4,
        ST_DISCHARGE = 3'd5,
        ST_HOLDOFF   = 3'd6
    } state_e;

endpackage

// File: rtl/chg_det_sync.sv
// Module: multi-bit flop-chain synchroniser for independent level flags.
// Assumes: each bit is a slow level; bits are not coherent with each other.
module chg_det_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar gs;
    generate
        for (gs = 0; gs < STAGES; gs++) begin : g_stage
            if (gs == 0) begin : g_first
                // First capture flop of the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Further settling flops.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[gs] <= '0;
                    else        chain[gs] <= chain[gs-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/chg_det_timer.sv
// Module: shared phase timer; reloaded on state entry, counts ticks down to 0.
// Assumes: a load in the same clock as a tick wins, so that tick is dropped.
module chg_det_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Reload on phase entry, otherwise count down once per tick and hold at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= load_val;
        else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    a_r3_timer_loads: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    a_r3_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/chg_det_fsm.sv
// Module: detection sequencer; contact, primary, optional secondary, attach,
//         discharge and hold-off phases, with type and budget decode.
// Assumes: all flag inputs are already synchronised; timer reloads on every
//          state change with the value for the state being entered.
module chg_det_fsm
    import chg_det_pkg::*;
#(
    parameter bit USE_DCD        = 1'b1,
    parameter bit USE_SEC        = 1'b1,
    parameter int T_DCD_TO_MS    = 600,
    parameter int T_DCD_DBNC_MS  = 10,
    parameter int T_PRI_MS       = 40,
    parameter int T_SEC_MS       = 40,
    parameter int T_DIS_MS       = 500,
    parameter int T_REATT_MS     = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             vbus_s,
    input  logic             vbus_low_s,
    input  logic             dp_ref_s,
    input  logic             dm_ref_s,
    input  logic             dp_low_s,
    input  logic             cfg_done,
    input  logic             draw_active,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             dp_isrc_en,
    output logic             dm_pd_en,
    output logic             dp_vsrc_en,
    output logic             dm_isink_en,
    output logic             dm_vsrc_en,
    output logic             dp_isink_en,
    output logic             dp_pullup_en,
    output logic             vbus_dis_en,
    output logic [1:0]       port_type,
    output logic [1:0]       ilim_code,
    output logic             det_done
);

    localparam int DBW = $clog2(T_DCD_DBNC_MS + 1) + 1;

    state_e state, state_nxt;
    port_e  type_q, type_nxt;
    logic   decide;
    logic   contact_ok;
    logic   live;

    // Contact debounce: variant chosen by the contact-detect option.
    generate
        if (USE_DCD) begin : g_dbnc
            logic [DBW-1:0] dbnc_cnt;
            // Count consecutive ticks with D+ below the low logic level.
            always_ff @(posedge clk) begin
                if (!rst_n || state != ST_CONTACT || !dp_low_s) dbnc_cnt <= '0;
                else if (tick && dbnc_cnt < DBW'(T_DCD_DBNC_MS)) dbnc_cnt <= dbnc_cnt + 1'b1;
            end
            assign contact_ok = (dbnc_cnt >= DBW'(T_DCD_DBNC_MS));
        end else begin : g_no_dbnc
            assign contact_ok = 1'b0;
        end
    endgenerate

    assign live = (state == ST_CONTACT) || (state == ST_PRIMARY) ||
                  (state == ST_SECONDARY) || (state == ST_ATTACHED);

    // Next-state and decided-type selection.
    always_comb begin
        state_nxt = state;
        type_nxt  = PORT_NONE;
        unique case (state)
            ST_IDLE:      if (vbus_s) state_nxt = ST_CONTACT;
            ST_CONTACT:   if (contact_ok || tmr_expired) state_nxt = ST_PRIMARY;
            ST_PRIMARY: begin
                if (tmr_expired) begin
                    if (!dm_ref_s) begin
                        state_nxt = ST_ATTACHED;
                        type_nxt  = PORT_SDP;
                    end else if (USE_SEC) begin
                        state_nxt = ST_SECONDARY;
                    end else begin
                        state_nxt = ST_ATTACHED;
                        type_nxt  = PORT_DCP;
                    end
                end
            end
            ST_SECONDARY: begin
                if (tmr_expired) begin
                    state_nxt = ST_ATTACHED;
                    type_nxt  = dp_ref_s ? PORT_DCP : PORT_CDP;
                end
            end
            ST_ATTACHED:  state_nxt = ST_ATTACHED;
            ST_DISCHARGE: if (vbus_low_s || tmr_expired) state_nxt = ST_HOLDOFF;
            ST_HOLDOFF:   if (tmr_expired) state_nxt = ST_IDLE;
            default:      state_nxt = ST_IDLE;
        endcase
        if (live && !vbus_s) state_nxt = ST_DISCHARGE;
    end

    assign decide = (state != ST_ATTACHED) && (state_nxt == ST_ATTACHED);

    // Timer reload value for the phase being entered.
    always_comb begin
        tmr_load = (state_nxt != state);
        unique case (state_nxt)
            ST_CONTACT:   tmr_val = TMR_W'(T_DCD_TO_MS);
            ST_PRIMARY:   tmr_val = TMR_W'(T_PRI_MS);
            ST_SECONDARY: tmr_val = TMR_W'(T_SEC_MS);
            ST_DISCHARGE: tmr_val = TMR_W'(T_DIS_MS);
            ST_HOLDOFF:   tmr_val = TMR_W'(T_REATT_MS);
            default:      tmr_val = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Port type register: set on decision, cleared on loss or idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                               type_q <= PORT_NONE;
        else if (state_nxt == ST_DISCHARGE || state_nxt == ST_IDLE) type_q <= PORT_NONE;
        else if (decide)                                          type_q <= type_nxt;
    end

    // One-clock decision strobe aligned with the new type.
    always_ff @(posedge clk) begin
        if (!rst_n) det_done <= 1'b0;
        else        det_done <= decide;
    end

    // Analog enable decode from the current phase.
    always_comb begin
        dp_isrc_en  = USE_DCD && (state == ST_CONTACT);
        dm_pd_en    = USE_DCD && (state == ST_CONTACT);
        dp_vsrc_en  = (state == ST_PRIMARY);
        dm_isink_en = (state == ST_PRIMARY);
        dm_vsrc_en  = (state == ST_SECONDARY);
        dp_isink_en = (state == ST_SECONDARY);
        vbus_dis_en = (state == ST_DISCHARGE);
        dp_pullup_en = 1'b0;
        if (state == ST_ATTACHED) begin
            unique case (type_q)
                PORT_SDP, PORT_CDP: dp_pullup_en = 1'b1;
                PORT_DCP:           dp_pullup_en = !USE_SEC && draw_active;
                default:            dp_pullup_en = 1'b0;
            endcase
        end
    end

    // Current budget decode from type and configuration.
    always_comb begin
        unique case (type_q)
            PORT_SDP:           ilim_code = cfg_done ? ILIM_500MA : ILIM_100MA;
            PORT_CDP, PORT_DCP: ilim_code = ILIM_1500MA;
            default:            ilim_code = ILIM_ZERO;
        endcase
    end

    assign port_type = type_q;

    // Checker-only tick count within the primary phase.
    logic [TMR_W-1:0] pri_ticks;
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_PRIMARY) pri_ticks <= '0;
        else if (tick)                     pri_ticks <= pri_ticks + 1'b1;
    end

    a_r3_primary_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIMARY && state_nxt != ST_PRIMARY && state_nxt != ST_DISCHARGE)
        |-> (pri_ticks == TMR_W'(T_PRI_MS)));

    a_r4_standard_port: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIMARY && tmr_expired && vbus_s && !dm_ref_s) |=> (port_type == PORT_SDP));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |=> !det_done);

    a_r6_done_has_type: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |-> (port_type != PORT_NONE));

    a_r7_no_type_no_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (port_type == PORT_NONE) |-> (ilim_code == ILIM_ZERO));

    a_r9_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vbus_s) |=> (port_type == PORT_NONE && !dp_pullup_en));

    a_r10_low_ends_dis: assert property (@(posedge clk) disable iff (!rst_n)
        (vbus_dis_en && vbus_low_s) |=> !vbus_dis_en);

    a_r12_one_group: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dp_isrc_en, dp_vsrc_en, dm_vsrc_en, vbus_dis_en, dp_pullup_en}));

endmodule

// File: rtl/chg_detect.sv
// Module: top of the charger port detection controller.
// Assumes: tick_1ms is a one-clock strobe in the clk domain; cfg_done and
//          draw_active are clk-domain levels; comparator flags are asynchronous.
module chg_detect
    import chg_det_pkg::*;
#(
    parameter bit USE_DCD       = 1'b1,
    parameter bit USE_SEC       = 1'b1,
    parameter int SYNC_STAGES   = 2,
    parameter int T_DCD_TO_MS   = 600,
    parameter int T_DCD_DBNC_MS = 10,
    parameter int T_PRI_MS      = 40,
    parameter int T_SEC_MS      = 40,
    parameter int T_DIS_MS      = 500,
    parameter int T_REATT_MS    = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1ms,
    input  logic       vbus_valid,
    input  logic       vbus_below_lkg,
    input  logic       dp_gt_ref,
    input  logic       dm_gt_ref,
    input  logic       dp_lt_lgc,
    input  logic       cfg_done,
    input  logic       draw_active,
    output logic       dp_isrc_en,
    output logic       dm_pd_en,
    output logic       dp_vsrc_en,
    output logic       dm_isink_en,
    output logic       dm_vsrc_en,
    output logic       dp_isink_en,
    output logic       dp_pullup_en,
    output logic       vbus_dis_en,
    output logic [1:0] port_type,
    output logic [1:0] ilim_code,
    output logic       det_done
);

    localparam int NFLAG = 5;

    logic [NFLAG-1:0] flags_s;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;

    chg_det_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({vbus_valid, vbus_below_lkg, dp_gt_ref, dm_gt_ref, dp_lt_lgc}),
        .sync_out (flags_s)
    );

    chg_det_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tick_1ms),
        .expired  (tmr_expired)
    );

    chg_det_fsm #(
        .USE_DCD       (USE_DCD),
        .USE_SEC       (USE_SEC),
        .T_DCD_TO_MS   (T_DCD_TO_MS),
        .T_DCD_DBNC_MS (T_DCD_DBNC_MS),
        .T_PRI_MS      (T_PRI_MS),
        .T_SEC_MS      (T_SEC_MS),
        .T_DIS_MS      (T_DIS_MS),
        .T_REATT_MS    (T_REATT_MS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick_1ms),
        .vbus_s       (flags_s[4]),
        .vbus_low_s   (flags_s[3]),
        .dp_ref_s     (flags_s[2]),
        .dm_ref_s     (flags_s[1]),
        .dp_low_s     (flags_s[0]),
        .cfg_done     (cfg_done),
        .draw_active  (draw_active),
        .tmr_expired  (tmr_expired),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .dp_isrc_en   (dp_isrc_en),
        .dm_pd_en     (dm_pd_en),
        .dp_vsrc_en   (dp_vsrc_en),
        .dm_isink_en  (dm_isink_en),
        .dm_vsrc_en   (dm_vsrc_en),
        .dp_isink_en  (dp_isink_en),
        .dp_pullup_en (dp_pullup_en),
        .vbus_dis_en  (vbus_dis_en),
        .port_type    (port_type),
        .ilim_code    (ilim_code),
        .det_done     (det_done)
    );

    a_r2_contact_pair: assert property (@(posedge clk) disable iff (!rst_n)
        dp_isrc_en |-> (dm_pd_en && !dp_vsrc_en));

    a_r3_primary_pair: assert property (@(posedge clk) disable iff (!rst_n)
        dp_vsrc_en |-> dm_isink_en);

endmodule

// File: tb/chg_detect_bench.sv
// Bench: two builds (full options / no options) on shared stimulus, with
// random comparator patterns from a fixed seed plus directed corners.
module chg_detect_bench;

    localparam int TD = 4;
    localparam int P_TO = 12, P_DB = 3, P_PRI = 6, P_SEC = 5, P_DIS = 10, P_RE = 8;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic vbus_valid = 1'b0, vbus_low = 1'b0, dp_ref = 1'b0, dm_ref = 1'b0, dp_lgc = 1'b0;
    logic cfg = 1'b0, draw = 1'b0;

    logic a_isrc, a_pd, a_vsrc, a_isink, a_dmv, a_dpi, a_pu, a_dis, a_done;
    logic b_isrc, b_pd, b_vsrc, b_isink, b_dmv, b_dpi, b_pu, b_dis, b_done;
    logic [1:0] a_type, a_ilim, b_type, b_ilim;

    int n_tests = 0, n_fail = 0, cyc = 0;
    int t0 = 0, rise_a = 0, rise_b = 0, run_a = 0, run_b = 0, last_a = 0, last_b = 0;
    int done_a = 0, done_b = 0, overlap = 0;
    bit finished = 1'b0;

    chg_detect #(.USE_DCD(1'b1), .USE_SEC(1'b1), .T_DCD_TO_MS(P_TO), .T_DCD_DBNC_MS(P_DB),
        .T_PRI_MS(P_PRI), .T_SEC_MS(P_SEC), .T_DIS_MS(P_DIS), .T_REATT_MS(P_RE)) u_chg_detect (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .vbus_valid(vbus_valid), .vbus_below_lkg(vbus_low),
        .dp_gt_ref(dp_ref), .dm_gt_ref(dm_ref), .dp_lt_lgc(dp_lgc), .cfg_done(cfg), .draw_active(draw),
        .dp_isrc_en(a_isrc), .dm_pd_en(a_pd), .dp_vsrc_en(a_vsrc), .dm_isink_en(a_isink),
        .dm_vsrc_en(a_dmv), .dp_isink_en(a_dpi), .dp_pullup_en(a_pu), .vbus_dis_en(a_dis),
        .port_type(a_type), .ilim_code(a_ilim), .det_done(a_done));

    chg_detect #(.USE_DCD(1'b0), .USE_SEC(1'b0), .T_DCD_TO_MS(P_TO), .T_DCD_DBNC_MS(P_DB),
        .T_PRI_MS(P_PRI), .T_SEC_MS(P_SEC), .T_DIS_MS(P_DIS), .T_REATT_MS(P_RE)) u_chg_detect_lite (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .vbus_valid(vbus_valid), .vbus_below_lkg(vbus_low),
        .dp_gt_ref(dp_ref), .dm_gt_ref(dm_ref), .dp_lt_lgc(dp_lgc), .cfg_done(cfg), .draw_active(draw),
        .dp_isrc_en(b_isrc), .dm_pd_en(b_pd), .dp_vsrc_en(b_vsrc), .dm_isink_en(b_isink),
        .dm_vsrc_en(b_dmv), .dp_isink_en(b_dpi), .dp_pullup_en(b_pu), .vbus_dis_en(b_dis),
        .port_type(b_type), .ilim_code(b_ilim), .det_done(b_done));

    // 50 MHz clock.
    initial forever #10 clk = ~clk;

    // Tick strobe: one clock in every TD, driven at the falling edge.
    initial forever begin
        repeat (TD - 1) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    end

    // Output monitor, sampled at the falling edge.
    logic pa = 1'b0, pb = 1'b0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (a_vsrc && !pa) rise_a <= cyc;
            if (b_vsrc && !pb) rise_b <= cyc;
            if (a_vsrc) run_a <= run_a + 1; else if (run_a != 0) begin last_a <= run_a; run_a <= 0; end
            if (b_vsrc) run_b <= run_b + 1; else if (run_b != 0) begin last_b <= run_b; run_b <= 0; end
            if (a_done) done_a <= done_a + 1;
            if (b_done) done_b <= done_b + 1;
            if ($countones({a_isrc, a_vsrc, a_dmv, a_dis, a_pu}) > 1 ||
                $countones({b_isrc, b_vsrc, b_dmv, b_dis, b_pu}) > 1) overlap <= overlap + 1;
        end
        pa <= a_vsrc;
        pb <= b_vsrc;
    end

    function automatic int exp_type(bit sec, bit dm, bit dp);
        if (!dm) return 1;
        if (sec) return dp ? 3 : 2;
        return 3;
    endfunction

    function automatic int exp_ilim(int t, bit c);
        if (t == 0) return 0;
        if (t == 1) return c ? 2 : 1;
        return 3;
    endfunction

    function automatic int exp_pull(bit sec, int t, bit d);
        if (t == 1 || t == 2) return 1;
        if (t == 3) return (!sec && d) ? 1 : 0;
        return 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_in(string req, int act, int lo, int hi);
        n_tests++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_result(bit dm, bit dp, bit lgc, bit d, bit timing);
        chk("R4/R5 full-build port type", int'(a_type), exp_type(1'b1, dm, dp));
        chk("R4/R5 lite-build port type", int'(b_type), exp_type(1'b0, dm, dp));
        chk("R6 full-build single det_done", done_a, 1);
        chk("R6 lite-build single det_done", done_b, 1);
        chk("R8 full-build pull-up", int'(a_pu), exp_pull(1'b1, exp_type(1'b1, dm, dp), d));
        chk("R8 lite-build pull-up", int'(b_pu), exp_pull(1'b0, exp_type(1'b0, dm, dp), d));
        chk_in("R3 full-build primary length", last_a, (P_PRI - 1) * TD, P_PRI * TD + 2);
        chk_in("R3 lite-build primary length", last_b, (P_PRI - 1) * TD, P_PRI * TD + 2);
        if (timing) begin
            chk_in("R1 lite-build timeout start", rise_b - t0, P_TO * TD - 2, P_TO * TD + 8);
            if (lgc) chk_in("R2 early contact start", rise_a - t0, (P_DB - 1) * TD, (P_DB + 1) * TD + 8);
            else     chk_in("R2 contact timeout start", rise_a - t0, P_TO * TD - 2, P_TO * TD + 8);
        end
    endtask

    // One attach/detach scenario with fixed comparator levels.
    task automatic scenario(bit dm, bit dp, bit lgc, bit d, bit fast_dis, bit quick);
        dm_ref = dm; dp_ref = dp; dp_lgc = lgc; draw = d; cfg = 1'b0; vbus_low = 1'b0;
        done_a = 0; done_b = 0;
        vbus_valid = 1'b1; t0 = cyc;
        wait_cyc(6);
        chk("R2 contact sources on", int'(a_isrc && a_pd), 1);
        chk("R1 lite-build no contact sources", int'(b_isrc || b_pd), 0);
        wait_cyc(150);
        check_result(dm, dp, lgc, d, 1'b1);
        chk("R7 full-build budget unconfigured", int'(a_ilim), exp_ilim(exp_type(1'b1, dm, dp), 1'b0));
        chk("R7 lite-build budget unconfigured", int'(b_ilim), exp_ilim(exp_type(1'b0, dm, dp), 1'b0));
        cfg = 1'b1; draw = !d;
        wait_cyc(2);
        chk("R7 full-build budget configured", int'(a_ilim), exp_ilim(exp_type(1'b1, dm, dp), 1'b1));
        chk("R8 lite-build pull-up follows draw", int'(b_pu), exp_pull(1'b0, exp_type(1'b0, dm, dp), !d));
        vbus_valid = 1'b0;
        wait_cyc(5);
        chk("R9 discharge on after loss", int'(a_dis && b_dis), 1);
        chk("R9 type and budget cleared", int'(a_type) + int'(b_type) + int'(a_ilim) + int'(b_ilim), 0);
        chk("R9 pull-ups off", int'(a_pu || b_pu), 0);
        if (fast_dis) begin
            vbus_low = 1'b1;
            wait_cyc(5);
            chk("R10 discharge ends on low VBUS", int'(a_dis || b_dis), 0);
            vbus_low = 1'b0;
            if (quick) begin
                vbus_valid = 1'b1;
                wait_cyc(P_RE * TD - 12);
                chk("R11 hold-off ignores VBUS", int'(a_isrc || a_vsrc || b_vsrc), 0);
                done_a = 0; done_b = 0;
                wait_cyc(200);
                check_result(dm, dp, lgc, !d, 1'b0);
                vbus_valid = 1'b0;
                wait_cyc(5);
                vbus_low = 1'b1;
                wait_cyc(5);
                vbus_low = 1'b0;
            end
        end else begin
            wait_cyc((P_DIS - 2) * TD - 3);
            chk("R10 discharge held until timeout", int'(a_dis && b_dis), 1);
            wait_cyc(3 * TD + 4);
            chk("R10 discharge ends on timeout", int'(a_dis || b_dis), 0);
        end
        wait_cyc(P_RE * TD + 12);
    endtask

    // Stimulus and checks.
    initial begin
        int seed;
        seed = $urandom(32'h5eed_c0de);
        wait_cyc(4);
        chk("R7 reset budget", int'(a_ilim) + int'(b_ilim), 0);
        chk("R6 reset type and strobe", int'(a_type) + int'(b_type) + int'(a_done) + int'(b_done), 0);
        chk("R9 reset enables off", int'(a_isrc || a_vsrc || a_dmv || a_pu || a_dis || b_vsrc || b_dis), 0);
        rst_n = 1'b1;
        wait_cyc(4);
        scenario(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        scenario(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        scenario(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        scenario(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 16; i++) begin
            logic [5:0] r;
            r = 6'($urandom);
            scenario(r[0], r[1], r[2], r[3], r[4], r[5]);
        end
        chk("R12 enable groups never overlap", overlap, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule